// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt causes of a 16550-style serial port into one interrupt identification byte and one interrupt request line. It takes the four interrupt-enable bits, receive error events, the receive FIFO fill level with its trigger selection, a character-time tick, the transmit-holding-empty condition and the modem-status delta flags. Host strobes for register accesses clear the latched causes. The shifter, the baud generator and the FIFO storage sit outside the block and feed it.

Four causes compete under a fixed priority. Line errors come first, then received data or a receive timeout, then transmit holding empty, then modem status. Only the highest enabled cause is reported. The pending flag in the identification byte is active low. The request line is that flag inverted and then gated by the OUT2 modem-control output.

Top module: `uart_int_ident`

## Requirements
- R1: A cause is reported only while its enable bit is set: ier_i[0] for received data and timeout, ier_i[1] for transmit empty, ier_i[2] for line status, ier_i[3] for modem status. With no enabled cause active, iir_o[0] is 1 and iir_o[2:1] is 00.
- R2: iir_o[2:1] names the highest-priority enabled cause: 11 line status over 10 received data or timeout, over 01 transmit empty, over 00 modem status.
- R3: iir_o[0] is 0 while any enabled cause is active and 1 otherwise.
- R4: iir_o[7:6] reads 11 when fifo_en_i is 1 and 00 when it is 0. iir_o[5:4] always reads 00.
- R5: With fifo_en_i set, the received-data cause is active while rx_level_i is at or above the trigger chosen by rx_trig_sel_i: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. With fifo_en_i clear, the threshold is 1. This cause is combinational, so it shows in the same cycle.
- R6: With fifo_en_i set and rx_level_i nonzero, the timeout becomes active once four char_tick_i cycles have been sampled with no rx_push_i and no rbr_rd_i. A push or a read restarts the count, and a read clears an active timeout after the next edge. While it is reported and the trigger has not been reached, iir_o reads code 10 with bit 3 set.
- R7: Any of the four error events (overrun, parity, framing, break) latches the line-status cause at the next edge. It holds until lsr_rd_i is sampled.
- R8: The transmit-empty cause is set at the edge that samples a rise of thr_empty_i. It clears on thr_wr_i, when thr_empty_i is 0, or on iir_rd_i while iir_o reports code 01 as pending. An identification read that reports another cause leaves it set.
- R9: irq_o equals (iir_o[0] == 0) AND out2_i.
- R10: The modem-status cause is active while any bit of msr_delta_i is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_trig_sel_i | input | 2 | Receive trigger selection |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_push_i | input | 1 | A byte entered the receive FIFO |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| char_tick_i | input | 1 | One character time elapsed |
| err_overrun_i | input | 1 | Overrun error event |
| err_parity_i | input | 1 | Parity error event |
| err_framing_i | input | 1 | Framing error event |
| err_break_i | input | 1 | Break detect event |
| lsr_rd_i | input | 1 | Line status read strobe |
| thr_empty_i | input | 1 | Transmit holding register empty |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_delta_i | input | 4 | Modem status delta flags |
| out2_i | input | 1 | OUT2 modem-control bit, gates irq_o |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Received-data and modem causes, the enable gating, the FIFO bits and irq_o follow the inputs in the same cycle. The bench checks them after the inputs settle, with no clock edge in between. Line status, transmit empty and timeout are latched, so each shows one edge after the strobe or tick that moves it. The bench holds each event for a set number of edges and samples 1 ns after the last one. Clearing strobes are checked the same way: one edge, then the output.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        ID_MODEM  = 2'b00,
        ID_THRE   = 2'b01,
        ID_RXDATA = 2'b10,
        ID_LINE   = 2'b11
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic rxtmo;
        logic thre;
        logic modem;
    } irq_src_t;

    typedef struct packed {
        logic overrun;
        logic parity;
        logic framing;
        logic brk;
    } rx_err_t;

    localparam int unsigned IER_BITS = 4;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
    parameter int unsigned TO_CHARS = 4,
    localparam int unsigned CNT_W = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en,
    input  logic has_data,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    output logic tmo_o
);

    logic [CNT_W-1:0] cnt_q;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TO_CHARS);

    always_ff @(posedge clk) begin
        if (rst || !fifo_en || !has_data || rx_push || rx_pop)
            cnt_q <= '0;
        else if (char_tick && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign tmo_o = (cnt_q == LIMIT);

    // R6: a receive buffer read drops the timeout after one edge
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> !tmo_o);

    // R6: the counter saturates and never passes its limit
    a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/uart_thre_src.sv
module uart_thre_src (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic ident_ack,
    output logic pend_o
);

    logic empty_q;
    logic rise;

    assign rise = thr_empty && !empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b0;
            pend_o  <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            if (rise)
                pend_o <= 1'b1;
            else if (thr_wr || ident_ack || !thr_empty)
                pend_o <= 1'b0;
        end
    end

    // R8: a holding-register write without a fresh rise clears the cause
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !(thr_empty && !empty_q)) |=> !pend_o);

    // R8: the cause only appears after an empty condition was sampled
    a_r8_set_needs_empty: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(thr_empty));

endmodule

// File: rtl/uart_line_src.sv
module uart_line_src
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_err_t err,
    input  logic    lsr_rd,
    output logic    pend_o
);

    logic any_err;
    assign any_err = |err;

    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (lsr_rd)
            pend_o <= 1'b0;
        else if (any_err)
            pend_o <= 1'b1;
    end

    // R7: a line status read always clears the latched cause
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        lsr_rd |=> !pend_o);

    // R7: an error event without a read is held at the next edge
    a_r7_latch: assert property (@(posedge clk) disable iff (rst)
        ((err != '0) && !lsr_rd) |=> pend_o);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t             src,
    input  logic [IER_BITS-1:0]  ier,
    input  logic                 fifo_en,
    output logic [7:0]           iir_o,
    output logic                 pending_o
);

    logic    en_line, en_rx, en_thre, en_modem;
    irq_id_e id;
    logic    tmo_flag;

    assign en_line  = src.line  && ier[2];
    assign en_rx    = (src.rxdata || src.rxtmo) && ier[0];
    assign en_thre  = src.thre  && ier[1];
    assign en_modem = src.modem && ier[3];

    always_comb begin
        id       = ID_MODEM;
        tmo_flag = 1'b0;
        if (en_line) begin
            id = ID_LINE;
        end else if (en_rx) begin
            id       = ID_RXDATA;
            tmo_flag = src.rxtmo && !src.rxdata;
        end else if (en_thre) begin
            id = ID_THRE;
        end
    end

    assign pending_o = en_line || en_rx || en_thre || en_modem;
    assign iir_o = {{2{fifo_en}}, 2'b00, tmo_flag, id, !pending_o};

    // R2: an enabled line-status cause always wins
    a_r2_line_first: assert final (!en_line || (iir_o[2:1] == 2'b11));

    // R1: with every enable clear nothing is reported
    a_r1_all_masked: assert final ((ier != '0) || (iir_o[0] && iir_o[3:1] == 3'b000));

    // R4: the reserved bits read zero
    a_r4_reserved: assert final (iir_o[5:4] == 2'b00);

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned LVL_W    = 5,
    parameter int unsigned TO_CHARS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          ier_i,
    input  logic                fifo_en_i,
    input  logic [1:0]          rx_trig_sel_i,
    input  logic [LVL_W-1:0]    rx_level_i,
    input  logic                rx_push_i,
    input  logic                rbr_rd_i,
    input  logic                char_tick_i,
    input  logic                err_overrun_i,
    input  logic                err_parity_i,
    input  logic                err_framing_i,
    input  logic                err_break_i,
    input  logic                lsr_rd_i,
    input  logic                thr_empty_i,
    input  logic                thr_wr_i,
    input  logic                iir_rd_i,
    input  logic [3:0]          msr_delta_i,
    input  logic                out2_i,
    output logic [7:0]          iir_o,
    output logic                irq_o
);

    irq_src_t    src;
    rx_err_t     errs;
    logic        has_data;
    int unsigned threshold;
    logic        pending;
    logic        ident_ack;

    assign errs      = '{overrun: err_overrun_i, parity: err_parity_i,
                         framing: err_framing_i, brk: err_break_i};
    assign has_data  = (rx_level_i != '0);
    assign threshold = fifo_en_i ? trig_bytes(rx_trig_sel_i) : 1;

    assign src.rxdata = (32'(rx_level_i) >= threshold);
    assign src.modem  = |msr_delta_i;

    uart_line_src u_line (
        .clk    (clk),
        .rst    (rst),
        .err    (errs),
        .lsr_rd (lsr_rd_i),
        .pend_o (src.line)
    );

    uart_rx_timeout #(.TO_CHARS(TO_CHARS)) u_tmo (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en_i),
        .has_data  (has_data),
        .rx_push   (rx_push_i),
        .rx_pop    (rbr_rd_i),
        .char_tick (char_tick_i),
        .tmo_o     (src.rxtmo)
    );

    assign ident_ack = iir_rd_i && !iir_o[0] && (iir_o[2:1] == ID_THRE);

    uart_thre_src u_thre (
        .clk       (clk),
        .rst       (rst),
        .thr_empty (thr_empty_i),
        .thr_wr    (thr_wr_i),
        .ident_ack (ident_ack),
        .pend_o    (src.thre)
    );

    uart_irq_prio u_prio (
        .src       (src),
        .ier       (ier_i),
        .fifo_en   (fifo_en_i),
        .iir_o     (iir_o),
        .pending_o (pending)
    );

    assign irq_o = pending && out2_i;

    // R9: the request line never rises without an active-low pending flag
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (!iir_o[0] && out2_i));

    // R4: the FIFO bits follow the enable
    a_r4_fifo_bits: assert property (@(posedge clk) disable iff (rst)
        iir_o[7:6] == {fifo_en_i, fifo_en_i});

    // R3: bit 3 only appears together with an active report of code 10
    a_r3_tmo_code: assert property (@(posedge clk) disable iff (rst)
        iir_o[3] |-> (!iir_o[0] && iir_o[2:1] == 2'b10));

endmodule

// File: tb/test_uart_int_ident.sv
`timescale 1ns/1ps
module test_uart_int_ident;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0]       ier_i;
    logic             fifo_en_i;
    logic [1:0]       rx_trig_sel_i;
    logic [LVL_W-1:0] rx_level_i;
    logic             rx_push_i, rbr_rd_i, char_tick_i;
    logic             err_overrun_i, err_parity_i, err_framing_i, err_break_i;
    logic             lsr_rd_i, thr_empty_i, thr_wr_i, iir_rd_i;
    logic [3:0]       msr_delta_i;
    logic             out2_i;
    logic [7:0]       iir_o;
    logic             irq_o;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    uart_int_ident #(.LVL_W(LVL_W), .TO_CHARS(4)) i_uart_int_ident (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_push_i = 0; rbr_rd_i = 0; char_tick_i = 0;
        err_overrun_i = 0; err_parity_i = 0; err_framing_i = 0; err_break_i = 0;
        lsr_rd_i = 0; thr_wr_i = 0; iir_rd_i = 0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1; ier_i = 0; fifo_en_i = 0; rx_trig_sel_i = 0; rx_level_i = 0;
        thr_empty_i = 0; msr_delta_i = 0; out2_i = 1;
        tick(); tick();
        rst = 0;
    endtask

    // Expected identification byte from the priority rules (R1-style gating per cause)
    function automatic logic [7:0] exp_iir(input logic [3:0] ier, input logic fifo,
                                           input logic ls, input logic rx, input logic to,
                                           input logic th, input logic ms);
        logic [7:0] v;
        v = {fifo, fifo, 6'b000001};
        if (ls && ier[2])                  v[3:0] = 4'b0110;
        else if ((rx || to) && ier[0])     v[3:0] = {to && !rx, 3'b100};
        else if (th && ier[1])             v[3:0] = 4'b0010;
        else if (ms && ier[3])             v[3:0] = 4'b0000;
        return v;
    endfunction

    initial begin
        #800000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] e;
        do_reset();
        tick();
        chk("R3 reset idle", iir_o, 8'h01);
        chk("R9 reset irq", {7'd0, irq_o}, 8'h00);

        // Sweep: enables x causes x fifo x out2 (R1 R2 R3 R4 R9 R10)
        for (int ie = 0; ie < 16; ie++)
            for (int m = 0; m < 16; m++)
                for (int f = 0; f < 2; f++)
                    for (int o = 0; o < 2; o++) begin
                        do_reset();
                        ier_i = 4'(ie); fifo_en_i = f[0]; out2_i = o[0];
                        rx_level_i = m[1] ? 5'd1 : 5'd0;
                        msr_delta_i = m[3] ? 4'b0100 : 4'b0000;
                        err_parity_i = m[0];
                        thr_empty_i = m[2];
                        tick();
                        err_parity_i = 0;
                        e = exp_iir(4'(ie), f[0], m[0], m[1], 1'b0, m[2], m[3]);
                        chk("R2 sweep iir", iir_o, e);
                        chk("R9 sweep irq", {7'd0, irq_o}, {7'd0, !e[0] && o[0]});
                    end

        // R5: trigger thresholds with FIFOs on
        do_reset();
        fifo_en_i = 1; ier_i = 4'b0001;
        for (int s = 0; s < 4; s++)
            for (int l = 0; l <= 16; l++) begin
                int t;
                t = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
                rx_trig_sel_i = 2'(s); rx_level_i = 5'(l);
                #1;
                chk("R5 trigger", iir_o, (l >= t) ? 8'hC4 : 8'hC1);
            end
        // R5: FIFOs off means a threshold of one byte
        fifo_en_i = 0; rx_trig_sel_i = 2'b11; rx_level_i = 1; #1;
        chk("R5 fifo off one byte", iir_o, 8'h04);

        // R6: timeout after four char times
        do_reset();
        fifo_en_i = 1; ier_i = 4'b0001; rx_trig_sel_i = 2'b01; rx_level_i = 1;
        char_tick_i = 1; tick(); tick(); tick(); char_tick_i = 0;
        chk("R6 three ticks", iir_o, 8'hC1);
        char_tick_i = 1; tick(); char_tick_i = 0;
        chk("R6 fourth tick", iir_o, 8'hCC);
        rbr_rd_i = 1; tick(); rbr_rd_i = 0;
        chk("R6 read clears", iir_o, 8'hC1);
        char_tick_i = 1; tick(); tick(); char_tick_i = 0;
        rx_push_i = 1; tick(); rx_push_i = 0;
        char_tick_i = 1; tick(); tick(); tick(); char_tick_i = 0;
        chk("R6 push restarts", iir_o, 8'hC1);
        char_tick_i = 1; tick(); char_tick_i = 0;
        chk("R6 after restart", iir_o, 8'hCC);
        rx_level_i = 4; #1;
        chk("R6 trigger hides bit3", iir_o, 8'hC4);
        fifo_en_i = 0; rx_level_i = 1;
        char_tick_i = 1; repeat (5) tick(); char_tick_i = 0;
        chk("R6 no timeout fifo off", iir_o, 8'h04);

        // R7: each error event latches until a line status read
        for (int k = 0; k < 4; k++) begin
            do_reset();
            ier_i = 4'b0100;
            {err_overrun_i, err_parity_i, err_framing_i, err_break_i} = 4'b1000 >> k;
            tick();
            idle();
            tick();
            chk("R7 error latched", iir_o, 8'h06);
            lsr_rd_i = 1; tick(); lsr_rd_i = 0;
            chk("R7 lsr read clears", iir_o, 8'h01);
        end

        // R8: transmit-empty set and clear paths
        do_reset();
        ier_i = 4'b0010;
        thr_empty_i = 1; tick();
        chk("R8 empty rise", iir_o, 8'h02);
        chk("R9 irq with out2", {7'd0, irq_o}, 8'h01);
        iir_rd_i = 1; tick(); iir_rd_i = 0;
        chk("R8 ident read clears", iir_o, 8'h01);
        thr_empty_i = 0; tick(); thr_empty_i = 1; tick();
        chk("R8 second rise", iir_o, 8'h02);
        thr_wr_i = 1; tick(); thr_wr_i = 0;
        chk("R8 write clears", iir_o, 8'h01);
        thr_empty_i = 0; tick(); thr_empty_i = 1; tick();
        ier_i = 4'b0011; rx_level_i = 1; #1;
        chk("R8 rx outranks", iir_o, 8'h04);
        iir_rd_i = 1; tick(); iir_rd_i = 0;
        rx_level_i = 0; #1;
        chk("R8 other read keeps", iir_o, 8'h02);
        out2_i = 0; #1;
        chk("R9 out2 gates", {7'd0, irq_o}, 8'h00);

        // R10: each modem delta bit
        do_reset();
        ier_i = 4'b1000;
        for (int b = 0; b < 4; b++) begin
            msr_delta_i = 4'(1 << b); #1;
            chk("R10 modem delta", iir_o, 8'h00);
        end
        msr_delta_i = 0; #1;
        chk("R10 no delta", iir_o, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule